// File: doc/BRIEF.md
# Two-Level SCL Phase Timing Generator

This block paces the clock line of a two-wire serial bus master. From the source clock it produces a one-cycle tick at every boundary between SCL half periods. Inside each half period it also produces a one-cycle strobe at the point where the master samples incoming data. The protocol engine uses these ticks to toggle SCL and uses the strobe to capture SDA. Computing the divider values and running the bus protocol are both outside this block.

Two counters are cascaded. A step counter advances on every enabled source cycle, and a sample counter advances each time the step counter wraps. A half period ends when both counters wrap in the same cycle, so it lasts (sample+1)×(step+1) source cycles. The SCL frequency is therefore the source clock divided by twice that product.

The limits come from one of two timing words:
- A standard/fast word with wide fields.
- A high-speed word with narrower fields.

The high-speed word takes effect only when its low two bits carry the enable code. Both words are held in a shadow register. The shadow copies them while the block is disabled, and otherwise only at a half-period boundary, so a change never shortens a phase that is already running.

Top module: `scl_timing_gen`

## Requirements
- R1: While rst_n is low, half_tick_o, sample_o and hs_mode_o are all low.
- R2: When the standard/fast word is in use, its bits 5:0 hold step-1 and its bits 10:8 hold sample-1. Every half period is then exactly (sample)×(step) source cycles long. half_tick_o pulses for one cycle at the end of each half period, and the first tick follows that many enabled cycles after enable_i rises.
- R3: The high-speed word is selected when its bits 1:0 equal 2'b11. Its bits 10:8 then hold step-1 and its bits 14:12 hold sample-1, the standard/fast word is ignored, and hs_mode_o is high.
- R4: A high-speed word whose bits 1:0 are not 2'b11 selects the standard/fast word, whatever its other bits hold, and hs_mode_o is low. This includes a word of zero.
- R5: sample_o pulses exactly once per half period. It pulses at the end of sample slot p, which is (p+1)×(step) cycles after the start of the half period. In standard/fast mode, p comes from bits 14:12 of the standard/fast word and is clamped to sample-1. In high-speed mode, p is 0.
- R6: While enable_i is low, both counters are held at zero and neither half_tick_o nor sample_o pulses. The shadow follows the timing words during this time, so hs_mode_o shows the mode that will be used.
- R7: Timing words that change while enabled take effect only from the next half-period boundary. hs_mode_o changes while enabled only in the cycle in which half_tick_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Runs the counters when high |
| std_timing_i | input | 16 | Standard/fast timing word |
| hs_timing_i | input | 16 | High-speed timing word |
| half_tick_o | output | 1 | One-cycle pulse at each SCL half-period boundary |
| sample_o | output | 1 | One-cycle data sample strobe |
| hs_mode_o | output | 1 | High while the shadowed configuration is high-speed |

## Verification
The bench builds the block with its default field widths: a 6-bit step field, 3-bit sample and sample-position fields, and a 3-bit high-speed step field. At these widths, all 64 high-speed step/sample combinations can be swept in full. The same sweep covers every sample value against step values that include both field extremes, and every sample position, including positions beyond the sample count that must be clamped. Boundary deferral is tested with words changed in the middle of a period, including a change from standard/fast to high-speed mode. Enable gating is tested by idling with enable low and then checking that counting restarts from zero.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
  localparam int REG_W        = 16;
  localparam int SF_STEP_LSB  = 0;
  localparam int SF_STEP_W    = 6;
  localparam int SF_SAMP_LSB  = 8;
  localparam int SAMP_W       = 3;
  localparam int SF_RDPOS_LSB = 12;
  localparam int HS_STEP_LSB  = 8;
  localparam int HS_STEP_W    = 3;
  localparam int HS_SAMP_LSB  = 12;
  localparam int HS_EN_W      = 2;
  localparam logic [HS_EN_W-1:0] HS_EN_CODE = 2'b11;

  typedef struct packed {
    logic                 hs;
    logic [SF_STEP_W-1:0] step_lim;
    logic [SAMP_W-1:0]    samp_lim;
    logic [SAMP_W-1:0]    rd_pos;
  } tg_cfg_t;
endpackage

// File: rtl/scl_tg_decode.sv
module scl_tg_decode
  import scl_tg_pkg::*;
(
  input  logic [REG_W-1:0] std_word_i,
  input  logic [REG_W-1:0] hs_word_i,
  output tg_cfg_t          cfg_o
);
  localparam int PAD_W = SF_STEP_W - HS_STEP_W;

  logic                 hs_sel;
  logic [SF_STEP_W-1:0] hs_step_ext;
  logic [SAMP_W-1:0]    sf_samp;
  logic [SAMP_W-1:0]    sf_pos;

  assign hs_sel = (hs_word_i[HS_EN_W-1:0] == HS_EN_CODE);

  generate
    if (PAD_W > 0) begin : g_pad
      assign hs_step_ext = {{PAD_W{1'b0}}, hs_word_i[HS_STEP_LSB +: HS_STEP_W]};
    end else begin : g_nopad
      assign hs_step_ext = hs_word_i[HS_STEP_LSB +: SF_STEP_W];
    end
  endgenerate

  assign sf_samp = std_word_i[SF_SAMP_LSB +: SAMP_W];
  assign sf_pos  = std_word_i[SF_RDPOS_LSB +: SAMP_W];

  always_comb begin
    cfg_o = '0;
    if (hs_sel) begin
      cfg_o.hs       = 1'b1;
      cfg_o.step_lim = hs_step_ext;
      cfg_o.samp_lim = hs_word_i[HS_SAMP_LSB +: SAMP_W];
      cfg_o.rd_pos   = '0;
    end else begin
      cfg_o.hs       = 1'b0;
      cfg_o.step_lim = std_word_i[SF_STEP_LSB +: SF_STEP_W];
      cfg_o.samp_lim = sf_samp;
      cfg_o.rd_pos   = (sf_pos > sf_samp) ? sf_samp : sf_pos;
    end
  end
endmodule

// File: rtl/scl_tg_shadow.sv
module scl_tg_shadow
  import scl_tg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load_i,
  input  tg_cfg_t cfg_i,
  output tg_cfg_t cfg_o
);
  tg_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/scl_tg_counter.sv
module scl_tg_counter
  import scl_tg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run_i,
  input  tg_cfg_t cfg_i,
  output logic    period_end_o,
  output logic    tick_o,
  output logic    strobe_o
);
  logic [SF_STEP_W-1:0] step_q;
  logic [SAMP_W-1:0]    samp_q;
  logic                 tick_q;
  logic                 strobe_q;
  logic                 step_end;
  logic                 samp_end;

  assign step_end     = (step_q == cfg_i.step_lim);
  assign samp_end     = (samp_q == cfg_i.samp_lim);
  assign period_end_o = run_i && step_end && samp_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= '0;
      samp_q   <= '0;
      tick_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else if (!run_i) begin
      step_q   <= '0;
      samp_q   <= '0;
      tick_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      step_q   <= step_end ? '0 : step_q + 1'b1;
      if (step_end) samp_q <= samp_end ? '0 : samp_q + 1'b1;
      tick_q   <= step_end && samp_end;
      strobe_q <= step_end && (samp_q == cfg_i.rd_pos);
    end
  end

  assign tick_o   = tick_q;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic [REG_W-1:0] std_timing_i,
  input  logic [REG_W-1:0] hs_timing_i,
  output logic             half_tick_o,
  output logic             sample_o,
  output logic             hs_mode_o
);
  tg_cfg_t next_cfg;
  tg_cfg_t live_cfg;
  logic    period_end;

  scl_tg_decode u_decode (
    .std_word_i (std_timing_i),
    .hs_word_i  (hs_timing_i),
    .cfg_o      (next_cfg)
  );

  scl_tg_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (!enable_i || period_end),
    .cfg_i  (next_cfg),
    .cfg_o  (live_cfg)
  );

  scl_tg_counter u_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (enable_i),
    .cfg_i        (live_cfg),
    .period_end_o (period_end),
    .tick_o       (half_tick_o),
    .strobe_o     (sample_o)
  );

  assign hs_mode_o = live_cfg.hs;
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable_i,
  input logic half_tick_o,
  input logic sample_o,
  input logic hs_mode_o
);
  logic        past_ok;
  logic [15:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      gap_q   <= '0;
    end else begin
      past_ok <= 1'b1;
      if (half_tick_o || !enable_i) gap_q <= '0;
      else if (gap_q != 16'hFFFF)   gap_q <= gap_q + 1'b1;
    end
  end

  a_r6_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !half_tick_o);

  a_r6_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !sample_o);

  a_r7_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(enable_i) && !$stable(hs_mode_o)) |-> half_tick_o);

  a_r3_hs_period_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_mode_o && enable_i && !half_tick_o) |-> (gap_q < 16'd64));

  always_comb begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!half_tick_o && !sample_o && !hs_mode_o);
    end
  end
endmodule

bind scl_timing_gen scl_timing_gen_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable_i    (enable_i),
  .half_tick_o (half_tick_o),
  .sample_o    (sample_o),
  .hs_mode_o   (hs_mode_o)
);

// File: tb/scl_timing_gen_tb_top.sv
module scl_timing_gen_tb_top;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] sf = '0;
  logic [15:0] hs = '0;
  logic        tick, strb, hsm;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_timing_gen dut_i (
    .clk (clk), .rst_n (rst_n), .enable_i (en),
    .std_timing_i (sf), .hs_timing_i (hs),
    .half_tick_o (tick), .sample_o (strb), .hs_mode_o (hsm)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_hs(input logic [15:0] h);
    return h[1:0] == 2'b11;
  endfunction

  function automatic int step_of(input logic [15:0] s, input logic [15:0] h);
    return is_hs(h) ? int'(h[10:8]) + 1 : int'(s[5:0]) + 1;
  endfunction

  function automatic int samp_of(input logic [15:0] s, input logic [15:0] h);
    return is_hs(h) ? int'(h[14:12]) + 1 : int'(s[10:8]) + 1;
  endfunction

  function automatic int strobe_at(input logic [15:0] s, input logic [15:0] h);
    int p;
    if (is_hs(h)) p = 0;
    else begin
      p = int'(s[14:12]);
      if (p > int'(s[10:8])) p = int'(s[10:8]);
    end
    return (p + 1) * step_of(s, h);
  endfunction

  // Runs two half periods from a fresh enable and checks tick/strobe timing.
  task automatic run_cfg(input logic [15:0] sf_v, input logic [15:0] hs_v,
                         input string req);
    int n, so, t_cnt, t_first, t_last, s_cnt, s_first, hs_seen;
    n = step_of(sf_v, hs_v) * samp_of(sf_v, hs_v);
    so = strobe_at(sf_v, hs_v);
    t_cnt = 0; t_first = 0; t_last = 0; s_cnt = 0; s_first = 0; hs_seen = 0;
    @(negedge clk);
    en = 1'b0; sf = sf_v; hs = hs_v;
    repeat (2) @(negedge clk);
    en = 1'b1;
    for (int k = 1; k <= 2*n; k++) begin
      @(negedge clk);
      if (tick) begin t_cnt++; if (t_first == 0) t_first = k; t_last = k; end
      if (strb) begin s_cnt++; if (s_first == 0) s_first = k; end
      if (k == 1) hs_seen = int'(hsm);
    end
    check(t_first == n, req, "first tick cycle", t_first, n);
    check(t_last == 2*n && t_cnt == 2, req, "second tick cycle", t_last, 2*n);
    check(s_cnt == 2, req, "R5 strobes in two half periods", s_cnt, 2);
    check(s_first == so, req, "R5 first strobe cycle", s_first, so);
    check(hs_seen == int'(is_hs(hs_v)), req, "mode flag", hs_seen, int'(is_hs(hs_v)));
    en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int bad;
    int steps[6] = '{0, 1, 2, 5, 31, 63};
    // R1: reset state
    sf = 16'h0303; hs = 16'h3303; en = 1'b1;
    repeat (3) @(negedge clk);
    check(!tick && !strb && !hsm, "R1", "outputs during reset", int'({tick, strb, hsm}), 0);
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: standard/fast sweep
    for (int sm = 0; sm < 8; sm++)
      for (int si = 0; si < 6; si++)
        run_cfg(16'(steps[si] | (sm << 8)), 16'h0000, "R2");

    // R5: sample position sweep including clamping
    for (int p = 0; p < 8; p++) run_cfg(16'(2 | (3 << 8) | (p << 12)), 16'h0000, "R5");

    // R3: full high-speed sweep, standard word ignored
    for (int sm = 0; sm < 8; sm++)
      for (int st = 0; st < 8; st++)
        run_cfg(16'h7A3F, 16'(3 | (st << 8) | (sm << 12)), "R3");

    // R4: high-speed word without enable code selects standard/fast
    run_cfg(16'h2104, 16'h0000, "R4");
    run_cfg(16'h2104, 16'h7702, "R4");
    run_cfg(16'h0205, 16'h5501, "R4");

    // R6: idle with enable low, no pulses; then restart from zero
    en = 1'b0; sf = 16'h0000; hs = 16'h0000;
    bad = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (tick || strb) bad++;
    end
    check(bad == 0, "R6", "pulses while disabled", bad, 0);
    hs = 16'h3303;
    @(negedge clk); @(negedge clk);
    check(hsm == 1'b1, "R6", "mode follows words while disabled", int'(hsm), 1);
    run_cfg(16'h0003, 16'h0000, "R6");

    // R7: change words mid-period, sf (N=8) -> sf (N=15)
    begin
      int t1, t2, t3, tc;
      t1 = 0; t2 = 0; t3 = 0; tc = 0;
      @(negedge clk);
      en = 1'b0; sf = 16'h0103; hs = 16'h0000;
      repeat (2) @(negedge clk);
      en = 1'b1;
      for (int k = 1; k <= 31; k++) begin
        @(negedge clk);
        if (k == 10) sf = 16'h0204;
        if (tick) begin
          tc++;
          if (tc == 1) t1 = k; else if (tc == 2) t2 = k; else if (tc == 3) t3 = k;
        end
      end
      check(t2 == 16, "R7", "old period kept after mid change", t2, 16);
      check(t3 == 31, "R7", "new period from boundary", t3, 31);
      en = 1'b0;
    end

    // R7: switch to high-speed mid-period; flag flips only at boundary
    begin
      int m_before, m_after, t2;
      m_before = 0; m_after = 0; t2 = 0;
      @(negedge clk);
      en = 1'b0; sf = 16'h0103; hs = 16'h0000;
      repeat (2) @(negedge clk);
      en = 1'b1;
      for (int k = 1; k <= 16; k++) begin
        @(negedge clk);
        if (k == 10) hs = 16'h1103;
        if (k == 15) m_before = int'(hsm);
        if (k == 16) begin m_after = int'(hsm); t2 = int'(tick); end
      end
      check(m_before == 0, "R7", "mode before boundary", m_before, 0);
      check(m_after == 1 && t2 == 1, "R7", "mode at boundary", m_after, 1);
      en = 1'b0;
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule